// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a read or write burst in a synchronous DRAM, or in a behavioural memory model used in a test environment. A column command loads a start column, a burst length code and a wrap order. From the next clock edge on, the block presents one column address per cycle and holds a burst-active flag high for as long as beats remain.

Two wrap orders are supported. In sequential order the low bits of the address count upward and wrap inside an aligned block whose size is the burst length. In interleaved order the beat number is XORed into those low bits. A full-page setting walks every column in turn, wrapping from the top column to zero, until a terminate strobe ends it. A new column command may arrive on any cycle and replaces the burst in progress. A terminate strobe ends a burst at once.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `active_o` is 0 and `col_o` is 0.
- R2: When `start_i` is 1 at a clock edge, `col_o` equals `start_col_i` and `active_o` is 1 after that edge.
- R3: The burst length code `blen_i` is 0, 1, 2 or 3 for 1, 2, 4 or 8 beats. `active_o` stays high for exactly that many cycles from the start edge and then falls, unless a start or stop intervenes.
- R4: With `wrap_i` = 0 (sequential), beat i has the address whose bits above log2(BL) equal those of the start column, and whose low log2(BL) bits equal (start low bits + i) mod BL.
- R5: With `wrap_i` = 1 (interleaved) and a fixed length, beat i has the upper bits of the start column, and its low log2(BL) bits equal the start low bits XOR i.
- R6: Any `blen_i` code from 4 to 7 selects full page. The address then rises by one each cycle and wraps from 255 to 0, and `active_o` stays high until a stop or a new start. `wrap_i` is ignored in this mode and the order is sequential.
- R7: When `stop_i` is 1 and `start_i` is 0 at an edge, `active_o` is 0 after that edge.
- R8: A start during an active burst restarts from the new column with the new length and order. When start and stop arrive in the same cycle, the start wins.
- R9: While `active_o` is 0 and no start arrives, `col_o` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Column command strobe: begin a burst |
| start_col_i | input | COL_W (8) | First column of the burst |
| blen_i | input | 3 | Burst length code: 0..3 = 1/2/4/8 beats, 4..7 = full page |
| wrap_i | input | 1 | Wrap order: 0 sequential, 1 interleaved |
| stop_i | input | 1 | Terminate strobe: end the current burst |
| col_o | output | COL_W (8) | Column address of the current beat |
| active_o | output | 1 | High while a burst beat is presented |

## Verification
On every cycle, the assertions check that a start loads its column, that a lone stop clears the active flag, and that the address is held while idle. They also check that a fixed-length burst never leaves its aligned block, and that a full-page burst steps by exactly one. Only the bench scenarios can show the full beat order of the sequential and interleaved wraps and the exact burst lengths for each code. The same holds for the full-page wrap from 255 to 0, which needs a start column near the top of the page, and for restart and start-over-stop priority in the middle of a burst.

// File: rtl/bcs_pkg.sv
// Package: shared encodings for the burst column address sequencer.
// Assumes the burst length code is 3 bits wide; codes above the largest
// fixed length select full-page operation.
package bcs_pkg;

    // Burst length codes seen on blen_i
    typedef enum logic [2:0] {
        BLEN_1    = 3'd0,
        BLEN_2    = 3'd1,
        BLEN_4    = 3'd2,
        BLEN_8    = 3'd3,
        BLEN_PAGE = 3'd7
    } blen_code_e;

    // Wrap order seen on wrap_i
    typedef enum logic {
        WRAP_SEQ   = 1'b0,
        WRAP_INTLV = 1'b1
    } wrap_e;

    // Largest fixed burst length expressed as log2
    localparam int unsigned MAX_BL_LOG2 = 3;

endpackage

// File: rtl/bcs_len_decode.sv
// Module: bcs_len_decode
// Turns a burst length code into a low-bit mask (BL-1) and a full-page flag.
// Assumes COL_W >= MAX_LOG2. Codes above MAX_LOG2 mean full page: the mask
// covers every column bit.
module bcs_len_decode #(
    parameter int unsigned COL_W    = 8,
    parameter int unsigned MAX_LOG2 = bcs_pkg::MAX_BL_LOG2
) (
    input  logic [2:0]       code_i,
    output logic [COL_W-1:0] mask_o,
    output logic             full_o
);
    localparam logic [2:0] MAX_CODE = 3'(MAX_LOG2);

    // Build the mask bit by bit from the code
    always_comb begin
        full_o = (code_i > MAX_CODE);
        for (int b = 0; b < int'(COL_W); b++) begin
            mask_o[b] = full_o || (b < int'(code_i));
        end
    end
endmodule

// File: rtl/bcs_addr_gen.sv
// Module: bcs_addr_gen
// Combinational address of a beat from the burst base column, the beat
// index and the low-bit mask. The upper bits always come from the base.
// Assumes the caller forces intlv_i low in full-page mode. With
// HAS_INTLV = 0 the interleaved path is not built.
module bcs_addr_gen #(
    parameter int unsigned COL_W     = 8,
    parameter bit          HAS_INTLV = 1'b1
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] idx_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             intlv_i,
    output logic [COL_W-1:0] addr_o
);
    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] low_sel;

    // Sequential low part: add the beat index to the base
    always_comb seq_low = base_i + idx_i;

    generate
        if (HAS_INTLV) begin : g_intlv
            // Pick between XOR order and counting order
            always_comb low_sel = intlv_i ? (base_i ^ idx_i) : seq_low;
        end else begin : g_seq_only
            // Only counting order is present
            always_comb low_sel = seq_low;
        end
    endgenerate

    // Merge the fixed upper bits with the wrapped low bits
    always_comb addr_o = (base_i & ~mask_i) | (low_sel & mask_i);
endmodule

// File: rtl/bcs_beat_tracker.sv
// Module: bcs_beat_tracker
// Counts beats and owns the burst-active flag. A start clears the index
// and raises active. A stop without a start drops it. A fixed-length
// burst ends after the beat whose index equals the mask. Assumes mask_i
// and full_i are the values latched at the start.
module bcs_beat_tracker #(
    parameter int unsigned COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             full_i,
    output logic             active_o,
    output logic [COL_W-1:0] idx_o,
    output logic             step_o
);
    logic last_beat;

    // The final beat of a fixed-length burst is on the bus
    always_comb last_beat = !full_i && (idx_o == mask_i);

    // Move to the next beat when active, not ending and not interrupted
    always_comb step_o = active_o && !start_i && !stop_i && !last_beat;

    // Update the active flag and the beat index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            idx_o    <= '0;
        end else if (start_i) begin
            active_o <= 1'b1;
            idx_o    <= '0;
        end else if (stop_i || (active_o && last_beat)) begin
            active_o <= 1'b0;
        end else if (step_o) begin
            idx_o    <= idx_o + 1'b1;
        end
    end
endmodule

// File: rtl/burst_col_seq.sv
// Module: burst_col_seq (top)
// Column address sequencer for SDRAM bursts. A start latches the column,
// the decoded length and the wrap order. Each following cycle presents the
// next beat's column on a registered output. Assumes start has priority
// over stop. Interleaved order is ignored in full-page mode.
module burst_col_seq #(
    parameter int unsigned COL_W     = 8,
    parameter bit          HAS_INTLV = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       blen_i,
    input  logic             wrap_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             active_o
);
    import bcs_pkg::*;

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic             full_q;
    logic             intlv_q;
    logic [COL_W-1:0] idx;
    logic [COL_W-1:0] idx_next;
    logic             step;
    logic [COL_W-1:0] next_addr;
    logic [COL_W-1:0] col_q;

    bcs_len_decode #(.COL_W(COL_W), .MAX_LOG2(MAX_BL_LOG2)) u_dec (
        .code_i (blen_i),
        .mask_o (dec_mask),
        .full_o (dec_full)
    );

    // Hold the burst setup for the lifetime of the burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            mask_q  <= '0;
            full_q  <= 1'b0;
            intlv_q <= 1'b0;
        end else if (start_i) begin
            base_q  <= start_col_i;
            mask_q  <= dec_mask;
            full_q  <= dec_full;
            intlv_q <= (wrap_i == WRAP_INTLV) && !dec_full;
        end
    end

    bcs_beat_tracker #(.COL_W(COL_W)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .stop_i   (stop_i),
        .mask_i   (mask_q),
        .full_i   (full_q),
        .active_o (active_o),
        .idx_o    (idx),
        .step_o   (step)
    );

    // Index of the beat that follows the current one
    always_comb idx_next = idx + 1'b1;

    bcs_addr_gen #(.COL_W(COL_W), .HAS_INTLV(HAS_INTLV)) u_gen (
        .base_i  (base_q),
        .idx_i   (idx_next),
        .mask_i  (mask_q),
        .intlv_i (intlv_q),
        .addr_o  (next_addr)
    );

    // Register the column presented on the output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
        end else if (start_i) begin
            col_q <= start_col_i;
        end else if (step) begin
            col_q <= next_addr;
        end
    end

    assign col_o = col_q;
endmodule

// File: rtl/bcs_checker.sv
// Module: bcs_checker
// Property checks on the sequencer ports. It keeps its own copy of the
// burst setup taken at each start. Attached to every burst_col_seq
// instance by the bind below.
module bcs_checker #(
    parameter int unsigned COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       blen_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             active_o
);
    logic [COL_W-1:0] chk_mask;
    logic             chk_full;

    // Record the length setting of the running burst
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_mask <= '0;
            chk_full <= 1'b0;
        end else if (start_i) begin
            chk_full <= (blen_i > 3'd3);
            chk_mask <= (blen_i > 3'd3) ? '1 : COL_W'((1 << blen_i) - 1);
        end
    end

    // R2: a start loads the column and raises active
    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (active_o && col_o == $past(start_col_i)));

    // R7: a stop without a start ends the burst
    p_stop_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !active_o);

    // R9: idle output holds its value
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !start_i) |=> $stable(col_o));

    // R6: a full-page burst steps by one and stays active
    p_page_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && chk_full && !start_i && !stop_i)
        |=> (active_o && col_o == COL_W'($past(col_o) + 1'b1)));

    // R4: a fixed-length burst never leaves its aligned block
    p_block_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !chk_full && !start_i && !stop_i)
        |=> ((col_o & ~chk_mask) == ($past(col_o) & ~chk_mask)));
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_bcs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .blen_i      (blen_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .active_o    (active_o)
);

// File: tb/sim_burst_col_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task applies one cycle of stimulus at the
// falling edge and queues the expected outputs. The monitor compares them
// just after the next rising edge.
module sim_burst_col_seq;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic [7:0] start_col_i;
    logic [2:0] blen_i;
    logic       wrap_i;
    logic       stop_i;
    logic [7:0] col_o;
    logic       active_o;

    int tests = 0;
    int fails = 0;

    logic [7:0] q_col[$];
    logic       q_act[$];
    string      q_tag[$];

    // Reference state, built from the requirements
    logic       m_act  = 1'b0;
    logic [7:0] m_col  = 8'h00;
    logic [7:0] m_base = 8'h00;
    int         m_idx  = 0;
    int         m_len  = 1;
    logic       m_full = 1'b0;
    logic       m_intl = 1'b0;

    always #2.5 clk = ~clk;

    burst_col_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .blen_i(blen_i), .wrap_i(wrap_i), .stop_i(stop_i),
        .col_o(col_o), .active_o(active_o)
    );

    // Beat address from the wrap rules in R4, R5 and R6
    function automatic logic [7:0] beat_addr(logic [7:0] base, int i, int len,
                                             logic full, logic intl);
        logic [7:0] msk;
        logic [7:0] lo;
        if (full) return 8'(base + i);
        msk = 8'(len - 1);
        lo  = intl ? (base ^ 8'(i)) : 8'(base + i);
        return (base & ~msk) | (lo & msk);
    endfunction

    // Drive one cycle and queue the expected result after the next edge
    task automatic step(input logic s, input logic [7:0] c, input logic [2:0] b,
                        input logic w, input logic t, input string tag);
        @(negedge clk);
        start_i = s; start_col_i = c; blen_i = b; wrap_i = w; stop_i = t;
        if (s) begin
            m_act = 1'b1; m_base = c; m_idx = 0; m_col = c;
            m_full = (b > 3'd3);
            m_len  = m_full ? 256 : (1 << b);
            m_intl = w && !m_full;
        end else if (t) begin
            m_act = 1'b0;
        end else if (m_act) begin
            if (!m_full && m_idx == m_len - 1) begin
                m_act = 1'b0;
            end else begin
                m_idx = m_idx + 1;
                m_col = beat_addr(m_base, m_idx, m_len, m_full, m_intl);
            end
        end
        q_col.push_back(m_col);
        q_act.push_back(m_act);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(1'b0, 8'h00, 3'd0, 1'b0, 1'b0, tag);
    endtask

    // Monitor: compare the queued expectation just after each rising edge
    always @(posedge clk) begin
        #2;
        if (q_col.size() != 0) begin
            logic [7:0] ec;
            logic       ea;
            string      et;
            ec = q_col.pop_front();
            ea = q_act.pop_front();
            et = q_tag.pop_front();
            tests++;
            if (col_o !== ec || active_o !== ea) begin
                fails++;
                $display("FAIL %s: col=%h act=%b expected col=%h act=%b",
                         et, col_o, active_o, ec, ea);
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #1000000;
        tests++; fails++;
        $display("FAIL watchdog: act=%b expected run to end", active_o);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; start_col_i = 8'h00;
        blen_i = 3'd0; wrap_i = 1'b0; stop_i = 1'b0;
        repeat (3) @(negedge clk);
        tests++;
        if (col_o !== 8'h00 || active_o !== 1'b0) begin
            fails++;
            $display("FAIL R1: col=%h act=%b expected col=00 act=0", col_o, active_o);
        end
        rst_n = 1'b1;
        idle(2, "R1");

        // R2 R3 R4: sequential bursts of each fixed length
        step(1'b1, 8'h35, 3'd0, 1'b0, 1'b0, "R2");  idle(2, "R3");
        step(1'b1, 8'h35, 3'd1, 1'b0, 1'b0, "R2");  idle(3, "R4");
        step(1'b1, 8'h36, 3'd2, 1'b0, 1'b0, "R2");  idle(5, "R4");
        step(1'b1, 8'hA5, 3'd3, 1'b0, 1'b0, "R2");  idle(9, "R4");
        idle(2, "R9");

        // R5: interleaved order
        step(1'b1, 8'h6B, 3'd3, 1'b1, 1'b0, "R5");  idle(9, "R5");
        step(1'b1, 8'h0E, 3'd2, 1'b1, 1'b0, "R5");  idle(5, "R5");
        step(1'b1, 8'h41, 3'd1, 1'b1, 1'b0, "R5");  idle(3, "R5");

        // R6: full page wraps 255 to 0, wrap setting ignored, then R7 stop
        step(1'b1, 8'hFC, 3'd7, 1'b1, 1'b0, "R6");  idle(8, "R6");
        step(1'b0, 8'h00, 3'd0, 1'b0, 1'b1, "R7");  idle(2, "R9");
        step(1'b1, 8'h10, 3'd5, 1'b0, 1'b0, "R6");  idle(3, "R6");
        step(1'b0, 8'h00, 3'd0, 1'b0, 1'b1, "R7");  idle(1, "R9");

        // R7: stop in the middle of a length-8 burst
        step(1'b1, 8'h20, 3'd3, 1'b0, 1'b0, "R7");  idle(3, "R7");
        step(1'b0, 8'h00, 3'd0, 1'b0, 1'b1, "R7");  idle(2, "R9");

        // R8: restart mid-burst and start beating stop
        step(1'b1, 8'h50, 3'd3, 1'b0, 1'b0, "R8");  idle(2, "R8");
        step(1'b1, 8'h9D, 3'd2, 1'b1, 1'b0, "R8");  idle(1, "R8");
        step(1'b1, 8'h03, 3'd2, 1'b0, 1'b1, "R8");  idle(5, "R8");
        step(1'b1, 8'h77, 3'd0, 1'b0, 1'b0, "R8");
        step(1'b1, 8'h78, 3'd0, 1'b0, 1'b0, "R8");  idle(2, "R3");

        @(posedge clk); #3;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule